// File: doc/BRIEF.md
# Selectable Bus Event Counter

This block is a performance counter that tallies exactly one class of bus event at a time. A small selector register chooses the class. Selector value 0 turns counting off. Values 1 through 7 each pick one of seven per-cycle event strobes that other logic supplies. Those strobes are, in order:

- cycles spent in the stalled state;
- shared writes issued locally;
- flushed sub-blocks;
- cycles spent waiting on a read-miss reply;
- write-update cycles;
- requests for owned data;
- writes to sub-blocks held neither shared nor owned.

Software writes the selector through a register port, and the write also restarts the count from zero. Software reads the running value on the count output and can zero it with a clear strobe.

While the fatal-error-pending flag is high, the counter freezes. It also freezes once it reaches its all-ones value.

Top module: `evt_counter`

## Requirements
- R1: While reset is active (synchronous, active low), the count and the selector readback are both zero on the following clock edge.
- R2: When `sel_wr_i` is high at a clock edge, `sel_o` shows `sel_wdata_i` after that edge.
- R3: When `sel_wr_i` is high at a clock edge, the count is zero after that edge, whatever the event strobes are.
- R4: When `cnt_clr_i` is high at a clock edge, the count is zero after that edge.
- R5: With selector 0, the count does not change, whatever the strobes are.
- R6: With selector k (1 to 7), the count increases by one on each edge where strobe bit k-1 of `evt_i` is high. The other six strobe bits have no effect.
- R7: While `fatal_pend_i` is high, the count does not change.
- R8: The count stops at 2^CNT_W-1 and does not wrap.
- R9: The count rises by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 7 | Per-cycle event strobes; bit k-1 belongs to selector k |
| fatal_pend_i | input | 1 | Fatal error pending; suspends counting |
| sel_wr_i | input | 1 | Selector write strobe (also clears the count) |
| sel_wdata_i | input | 3 | New selector value |
| cnt_clr_i | input | 1 | Clear strobe for the count |
| count_o | output | CNT_W (32) | Current count |
| sel_o | output | 3 | Selector readback |

## Verification
All results are registered once. A selector write, a clear, or an event strobe presented before a clock edge shows on `sel_o` and `count_o` right after that edge. Its effect must be visible there. The bench drives inputs on the falling edge. On the next falling edge it compares both outputs with the values its reference function computed from the previous state and inputs, so every comparison falls exactly one edge after its stimulus. The bench uses an 8-bit count so that saturation can be reached within the run.

// File: rtl/evc_pkg.sv
// Shared definitions for the selectable event counter.
// Assumes a 3-bit selector whose value 0 means "off".
package evc_pkg;
    localparam int EVC_SEL_W = 3;
    localparam int EVC_N_EVT = (1 << EVC_SEL_W) - 1;
    typedef logic [EVC_SEL_W-1:0] evc_sel_t;
endpackage

// File: rtl/evc_sel_reg.sv
// Selector register: holds the event class chosen by software.
// Assumes the write strobe is a single-cycle pulse from the register port.
module evc_sel_reg
    import evc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_i,
    input  evc_sel_t wdata_i,
    output evc_sel_t sel_o
);
    evc_sel_t sel_q;

    // Capture a new selector on a write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    sel_q <= '0;
        else if (wr_i) sel_q <= wdata_i;
    end

    assign sel_o = sel_q;

    assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> sel_o == $past(wdata_i));
endmodule

// File: rtl/evc_evt_mux.sv
// Event picker: forwards the strobe chosen by the selector as one increment
// request. Selector 0 maps to a constant zero, and a pending fatal error
// blocks the request.
module evc_evt_mux
    import evc_pkg::*;
#(
    parameter int N_EVT = EVC_N_EVT
) (
    input  evc_sel_t         sel_i,
    input  logic [N_EVT-1:0] evt_i,
    input  logic             fatal_i,
    output logic             hit_o
);
    localparam int N_SLOT = N_EVT + 1;
    logic [N_SLOT-1:0] slot;

    // Slot 0 is the "off" code; slots 1..N_EVT carry the strobes.
    assign slot[0] = 1'b0;
    for (genvar k = 1; k < N_SLOT; k++) begin : g_slot
        assign slot[k] = evt_i[k-1];
    end

    // Choose the active slot and gate it with the fatal flag.
    always_comb begin
        hit_o = slot[sel_i] & ~fatal_i;
    end
endmodule

// File: rtl/evc_sat_cnt.sv
// Saturating up-counter: counts by one per request and stops at all ones.
// A clear has priority over an increment.
module evc_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MAXV = '1;
    logic [W-1:0] cnt_q;

    // Clear, step, or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (clr_i)                  cnt_q <= '0;
        else if (inc_i && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_o == '0);
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == MAXV && !clr_i) |=> cnt_o == MAXV);
    assert_one_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/evt_counter.sv
// Selectable bus event counter, top level.
// Assumes the event strobes are synchronous to clk and one cycle wide per event.
module evt_counter
    import evc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVC_N_EVT-1:0] evt_i,
    input  logic                 fatal_pend_i,
    input  logic                 sel_wr_i,
    input  logic [EVC_SEL_W-1:0] sel_wdata_i,
    input  logic                 cnt_clr_i,
    output logic [CNT_W-1:0]     count_o,
    output logic [EVC_SEL_W-1:0] sel_o
);
    evc_sel_t sel;
    logic     hit;
    logic     zap;

    // A selector write and an explicit clear both restart the count.
    assign zap = sel_wr_i | cnt_clr_i;

    evc_sel_reg i_sel (
        .clk(clk), .rst_n(rst_n), .wr_i(sel_wr_i),
        .wdata_i(sel_wdata_i), .sel_o(sel)
    );

    evc_evt_mux #(.N_EVT(EVC_N_EVT)) i_mux (
        .sel_i(sel), .evt_i(evt_i), .fatal_i(fatal_pend_i), .hit_o(hit)
    );

    evc_sat_cnt #(.W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(zap), .inc_i(hit), .cnt_o(count_o)
    );

    assign sel_o = sel;

    assert_wr_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr_i |=> count_o == '0);
    assert_off_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == '0 && !zap) |=> $stable(count_o));
    assert_fatal_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal_pend_i && !zap) |=> $stable(count_o));
endmodule

// File: tb/test_evt_counter.sv
`timescale 1ns/1ps
module test_evt_counter;
    localparam int TB_W = 8;
    localparam logic [TB_W-1:0] TB_MAX = '1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [6:0]      evt = '0;
    logic            fatal = 1'b0;
    logic            wr = 1'b0;
    logic [2:0]      wd = '0;
    logic            clr = 1'b0;
    logic [TB_W-1:0] count;
    logic [2:0]      sel;

    int              n_run = 0;
    int              n_fail = 0;
    logic [TB_W-1:0] exp_cnt = '0;
    logic [2:0]      exp_sel = '0;
    string           why = "R1";

    evt_counter #(.CNT_W(TB_W)) i_evt_counter (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .fatal_pend_i(fatal),
        .sel_wr_i(wr), .sel_wdata_i(wd), .cnt_clr_i(clr),
        .count_o(count), .sel_o(sel)
    );

    always #2 clk = ~clk;

    // Reference next count, derived from the requirements.
    function automatic logic [TB_W-1:0] ref_cnt(logic [TB_W-1:0] c, logic [2:0] s,
            logic [6:0] e, logic f, logic w, logic cl);
        if (w || cl) return '0;
        if (s == 0 || f || c == TB_MAX) return c;
        return e[s-1] ? c + 1'b1 : c;
    endfunction

    // Requirement that explains the expected change.
    function automatic string ref_tag(logic [TB_W-1:0] c, logic [2:0] s, logic f,
            logic w, logic cl);
        if (w) return "R3";
        if (cl) return "R4";
        if (s == 0) return "R5";
        if (f) return "R7";
        if (c == TB_MAX) return "R8";
        return "R6 R9";
    endfunction

    task automatic check_now();
        n_run++;
        if (count !== exp_cnt) begin
            n_fail++;
            $display("FAIL %s count: actual %0d expected %0d", why, count, exp_cnt);
        end
        n_run++;
        if (sel !== exp_sel) begin
            n_fail++;
            $display("FAIL R2 sel: actual %0d expected %0d", sel, exp_sel);
        end
    endtask

    // One cycle: check the last result, then drive new inputs and predict.
    task automatic step(logic w, logic [2:0] d, logic cl, logic [6:0] e, logic f);
        @(negedge clk);
        check_now();
        wr = w; wd = d; clr = cl; evt = e; fatal = f;
        why = ref_tag(exp_cnt, exp_sel, f, w, cl);
        exp_cnt = ref_cnt(exp_cnt, exp_sel, e, f, w, cl);
        if (w) exp_sel = d;
    endtask

    initial begin
        process::self().srandom(32'd7411);
        evt = 7'h7F; wr = 1'b1; wd = 3'd5; clr = 1'b0;
        repeat (3) @(negedge clk);
        why = "R1";
        check_now();                         // R1 reset state
        @(negedge clk);
        rst_n = 1'b1; wr = 1'b0; evt = '0;
        // Directed: selector 0 ignores all strobes (R5).
        repeat (4) step(0, 0, 0, 7'h7F, 0);
        // Directed: selector 3 counts only bit 2 (R6).
        step(1, 3'd3, 0, 7'h7F, 0);
        repeat (5) step(0, 0, 0, 7'h04, 0);
        repeat (5) step(0, 0, 0, 7'h7B, 0);
        // Directed: fatal pending freezes (R7).
        repeat (4) step(0, 0, 0, 7'h7F, 1);
        // Directed: clear (R4).
        step(0, 0, 1, 7'h7F, 0);
        // Directed: saturation with selector 7 (R8).
        step(1, 3'd7, 0, 7'h40, 0);
        repeat (TB_MAX + 10) step(0, 0, 0, 7'h40, 0);
        // Directed: write during event clears (R3).
        step(1, 3'd7, 0, 7'h40, 0);
        // Random phase.
        for (int i = 0; i < 3000; i++) begin
            logic w, cl, f;
            w  = ($urandom % 40) == 0;
            cl = ($urandom % 60) == 0;
            f  = ($urandom % 8) == 0;
            step(w, 3'($urandom), cl, 7'($urandom), f);
        end
        @(negedge clk);
        check_now();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule